// File: doc/BRIEF.md
# Eight-Row Stationary-Weight Dot-Product Accumulator

This block is the arithmetic core of a weight-stationary contraction unit. Each of eight rows keeps its own vector of 32 signed weights in local registers. Software loads a row once, and the weights stay in place while activation vectors stream past. Every streamed vector goes to all rows at the same time. Each row multiplies the vector lane by lane with its weights and adds the 32 products in a registered adder tree. It then adds that spatial sum into a 32-bit accumulator.

The accumulator runs over one time group. A group is a run of valid steps that ends with a step carrying the end-of-group marker. When that last step leaves the pipeline, all eight row totals appear on the output for one cycle. Lanes hold signed 8-bit values, or signed 4-bit values taken from the low nibble of each byte. A configuration field enables 1, 2, 4 or 8 rows. Zero weights provide padding lanes whose inputs carry arbitrary data.

Top module: `rowwise_mac_array`

## Requirements
- R1: After reset, `res_valid` is 0, `res_data` is all zeros and `wt_ready` is 1.
- R2: When `wt_we` is 1 and `wt_ready` is 1, row `wt_row` takes `wt_data` as its weights. Lane i of a row is at bits [8i+7:8i]. The weights remain in use for every later group until that row is written again.
- R3: With `mode_nib` = 0, the spatial sum of an enabled row is the sum over all 32 lanes of `act_data` lane i times weight lane i. Each lane is a signed 8-bit value at bits [8i+7:8i].
- R4: With `mode_nib` = 1, each activation lane and each weight lane is the sign-extended low nibble (bits [8i+3:8i]). The upper nibble of every lane has no effect on the result.
- R5: `res_valid` rises exactly 5 clock edges after the edge that samples `act_valid` with `act_last` in 8-bit mode, and exactly 6 edges after it in 4-bit mode.
- R6: Each row result is the sum of the spatial sums of all steps in the group. The first step after reset, or after a last step, restarts the total. `res_valid` is 1 for a single cycle, and only for a last step.
- R7: `row_cfg` values 0, 1, 2 and 3 enable rows 0..0, 0..1, 0..3 and 0..7. A disabled row reports 0 in its 32-bit slice of `res_data`, where row r sits at bits [32r+31:32r].
- R8: `wt_ready` is 0 from the edge that samples a valid non-last step until the edge that samples a valid last step. A weight write offered while `wt_ready` is 0 has no effect.
- R9: Accumulation wraps modulo 2^32 in two's complement, with no saturation.
- R10: A lane whose weight is zero adds nothing to the row result, whatever its activation value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_nib | input | 1 | 1 selects 4-bit lanes, 0 selects 8-bit lanes; change only when idle |
| row_cfg | input | 2 | Enabled row count as log2 (1, 2, 4, 8) |
| wt_we | input | 1 | Weight write strobe |
| wt_row | input | 3 | Row addressed by the weight write |
| wt_data | input | 256 | 32 weight lanes of 8 bits |
| wt_ready | output | 1 | Weight writes are accepted |
| act_valid | input | 1 | Streamed activation step present |
| act_last | input | 1 | Step closes the time group |
| act_data | input | 256 | 32 activation lanes of 8 bits |
| res_valid | output | 1 | Row totals valid for one cycle |
| res_data | output | 256 | Eight 32-bit signed row totals |

## Verification
Four properties are checked on every cycle. A result pulse must follow a last step after exactly the pipeline delay for the current lane width. The weight registers must not move while a group is open. The ready flag must drop after a non-last step. Disabled rows must read zero whenever results are presented. Only the bench scenarios can show the arithmetic: correct dot products in both lane widths, nibble masking, totals across steps, reuse of weights across groups, padding lanes, and wrap-around after thousands of saturated steps. The expected values come from integer arithmetic in the bench.

// File: rtl/rowwise_mac_array.sv
module rowwise_mac_array #(
  parameter int ROWS  = 8,
  parameter int LANES = 32,
  parameter int ACC_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     mode_nib,
  input  logic [1:0]               row_cfg,
  input  logic                     wt_we,
  input  logic [$clog2(ROWS)-1:0]  wt_row,
  input  logic [LANES*8-1:0]       wt_data,
  output logic                     wt_ready,
  input  logic                     act_valid,
  input  logic                     act_last,
  input  logic [LANES*8-1:0]       act_data,
  output logic                     res_valid,
  output logic [ROWS*ACC_W-1:0]    res_data
);
  localparam int LW = 8;
  localparam int PW = 2 * LW;
  localparam int SW = PW + $clog2(LANES);
  localparam int L1 = LANES / 4;
  localparam int L2 = L1 / 4;
  localparam int VW = LANES * LW;

  function automatic logic signed [LW-1:0] ext(input logic [LW-1:0] b, input logic nib);
    return nib ? {{(LW-4){b[3]}}, b[3:0]} : b;
  endfunction

  logic [ROWS*VW-1:0] w_flat;
  logic               grp_open;
  logic [ROWS-1:0]    row_en;

  assign wt_ready = !grp_open;

  always_comb
    for (int r = 0; r < ROWS; r++)
      row_en[r] = r < (32'd1 << row_cfg);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      w_flat   <= '0;
      grp_open <= 1'b0;
    end else begin
      if (wt_we && !grp_open) w_flat[int'(wt_row)*VW +: VW] <= wt_data;
      if (act_valid) grp_open <= !act_last;
    end

  logic signed [PW-1:0] prod [ROWS][LANES];
  logic signed [SW-1:0] s1   [ROWS][L1];
  logic signed [SW-1:0] s2   [ROWS][L2];
  logic signed [SW-1:0] s3   [ROWS];
  logic signed [SW-1:0] s4   [ROWS];
  logic signed [SW-1:0] s1_d [ROWS][L1];
  logic signed [SW-1:0] s2_d [ROWS][L2];
  logic signed [SW-1:0] s3_d [ROWS];
  logic [4:0] vp, lp;

  always_comb
    for (int r = 0; r < ROWS; r++) begin
      for (int g = 0; g < L1; g++) begin
        s1_d[r][g] = '0;
        for (int k = 0; k < 4; k++) s1_d[r][g] = s1_d[r][g] + SW'(prod[r][4*g+k]);
      end
      for (int g = 0; g < L2; g++) begin
        s2_d[r][g] = '0;
        for (int k = 0; k < 4; k++) s2_d[r][g] = s2_d[r][g] + s1[r][4*g+k];
      end
      s3_d[r] = '0;
      for (int g = 0; g < L2; g++) s3_d[r] = s3_d[r] + s2[r][g];
    end

  always_ff @(posedge clk)
    for (int r = 0; r < ROWS; r++) begin
      for (int l = 0; l < LANES; l++)
        prod[r][l] <= row_en[r]
          ? PW'(ext(act_data[l*LW +: LW], mode_nib)) * PW'(ext(w_flat[r*VW + l*LW +: LW], mode_nib))
          : '0;
      s1[r] <= s1_d[r];
      s2[r] <= s2_d[r];
      s3[r] <= s3_d[r];
      s4[r] <= s3[r];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      vp <= '0;
      lp <= '0;
    end else begin
      vp <= {vp[3:0], act_valid};
      lp <= {lp[3:0], act_valid && act_last};
    end

  wire src_v = mode_nib ? vp[4] : vp[3];
  wire src_l = mode_nib ? lp[4] : lp[3];

  logic [ACC_W-1:0] acc     [ROWS];
  logic [ACC_W-1:0] acc_nxt [ROWS];
  logic             first;

  always_comb
    for (int r = 0; r < ROWS; r++)
      acc_nxt[r] = (first ? '0 : acc[r]) + ACC_W'(mode_nib ? s4[r] : s3[r]);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      first     <= 1'b1;
      res_valid <= 1'b0;
      res_data  <= '0;
      for (int r = 0; r < ROWS; r++) acc[r] <= '0;
    end else begin
      res_valid <= src_v && src_l;
      if (src_v) begin
        first <= src_l;
        for (int r = 0; r < ROWS; r++) begin
          acc[r] <= acc_nxt[r];
          if (src_l) res_data[r*ACC_W +: ACC_W] <= acc_nxt[r];
        end
      end
    end
endmodule

module rowwise_mac_array_chk #(
  parameter int ROWS  = 8,
  parameter int LANES = 32,
  parameter int ACC_W = 32
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   mode_nib,
  input logic [1:0]             row_cfg,
  input logic                   act_valid,
  input logic                   act_last,
  input logic                   wt_ready,
  input logic                   res_valid,
  input logic [ROWS*ACC_W-1:0]  res_data,
  input logic [ROWS*LANES*8-1:0] w_flat
);
  logic [2:0] cyc;
  logic       hi_zero;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= '0;
    else if (cyc != 3'd7) cyc <= cyc + 3'd1;

  always_comb begin
    hi_zero = 1'b1;
    for (int r = 0; r < ROWS; r++)
      if (r >= (32'd1 << row_cfg) && res_data[r*ACC_W +: ACC_W] != '0) hi_zero = 1'b0;
  end

  assert_latency_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 3'd6 && res_valid && !mode_nib) |-> $past(act_valid && act_last, 5));

  assert_latency_nib_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 3'd7 && res_valid && mode_nib) |-> $past(act_valid && act_last, 6));

  assert_group_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (act_valid && !act_last) |=> !wt_ready);

  assert_weights_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wt_ready |=> $stable(w_flat));

  assert_disabled_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> hi_zero);
endmodule

bind rowwise_mac_array rowwise_mac_array_chk #(.ROWS(ROWS), .LANES(LANES), .ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_nib(mode_nib), .row_cfg(row_cfg),
  .act_valid(act_valid), .act_last(act_last), .wt_ready(wt_ready),
  .res_valid(res_valid), .res_data(res_data), .w_flat(w_flat));

// File: tb/test_rowwise_mac_array.sv
`timescale 1ns/1ps
module test_rowwise_mac_array;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_nib = 1'b0;
  logic [1:0] row_cfg = 2'd3;
  logic wt_we = 1'b0;
  logic [2:0] wt_row = '0;
  logic [255:0] wt_data = '0;
  logic wt_ready;
  logic act_valid = 1'b0, act_last = 1'b0;
  logic [255:0] act_data = '0;
  logic res_valid;
  logic [255:0] res_data;

  int total = 0, bad = 0;
  bit done = 0;
  int wb [8][32];

  always #4 clk = ~clk;

  rowwise_mac_array i_rowwise_mac_array (
    .clk(clk), .rst_n(rst_n), .mode_nib(mode_nib), .row_cfg(row_cfg),
    .wt_we(wt_we), .wt_row(wt_row), .wt_data(wt_data), .wt_ready(wt_ready),
    .act_valid(act_valid), .act_last(act_last), .act_data(act_data),
    .res_valid(res_valid), .res_data(res_data));

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int lane(input int b, input bit nib);
    int n;
    if (nib) begin n = b & 15; return (n >= 8) ? n - 16 : n; end
    return (b >= 128) ? b - 256 : b;
  endfunction

  function automatic int act_byte(input int pat, input int seed, input int step, input int l);
    if (pat == 1) return 128;
    return (seed * 37 + step * 53 + l * 29 + 11) & 255;
  endfunction

  task automatic load_row(input int r, input int seed, input int pat);
    wt_we = 1'b1;
    wt_row = 3'(r);
    for (int l = 0; l < 32; l++) begin
      int b;
      if (pat == 1) b = 128;
      else if (pat == 2 && (l % 2 == 0)) b = 0;
      else b = (seed * 71 + r * 19 + l * 23 + 5) & 255;
      wt_data[8*l +: 8] = 8'(b);
      wb[r][l] = b;
    end
    @(negedge clk);
    wt_we = 1'b0;
  endtask

  // Streams one group; optionally offers a write (wr_try) between first and second step.
  task automatic run_group(input string req, input int seed, input int nsteps, input bit nib,
                           input int rcfg, input int pat, input bit wr_try);
    logic [31:0] exp [8];
    int lat;
    lat = nib ? 6 : 5;
    mode_nib = nib;
    row_cfg = 2'(rcfg);
    @(negedge clk);
    for (int r = 0; r < 8; r++) exp[r] = '0;
    for (int s = 0; s < nsteps; s++) begin
      act_valid = 1'b1;
      act_last = (s == nsteps - 1);
      for (int l = 0; l < 32; l++) act_data[8*l +: 8] = 8'(act_byte(pat, seed, s, l));
      for (int r = 0; r < 8; r++)
        if (r < (1 << rcfg))
          for (int l = 0; l < 32; l++)
            exp[r] = exp[r] + 32'(lane(act_byte(pat, seed, s, l), nib) * lane(wb[r][l], nib));
      @(negedge clk);
      if (wr_try && s == 0 && nsteps > 1) begin
        act_valid = 1'b0;
        chk(wt_ready == 1'b0, "R8", "ready during open group", wt_ready, 0);
        wt_we = 1'b1;
        wt_row = 3'd0;
        wt_data = '1;
        @(negedge clk);
        wt_we = 1'b0;
      end
    end
    act_valid = 1'b0;
    act_last = 1'b0;
    if (wr_try) chk(wt_ready == 1'b1, "R8", "ready after last step", wt_ready, 1);
    repeat (lat - 2) @(negedge clk);
    chk(res_valid == 1'b0, "R5", "valid one cycle early", res_valid, 0);
    @(negedge clk);
    chk(res_valid == 1'b1, "R5", "valid at latency", res_valid, 1);
    for (int r = 0; r < 8; r++)
      chk(res_data[32*r +: 32] == exp[r], req, $sformatf("row %0d total", r),
          longint'($signed(res_data[32*r +: 32])), longint'($signed(exp[r])));
    @(negedge clk);
    chk(res_valid == 1'b0, "R6", "single-cycle valid", res_valid, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(res_valid == 1'b0, "R1", "reset valid", res_valid, 0);
    chk(res_data == '0, "R1", "reset data", res_data[31:0], 0);
    chk(wt_ready == 1'b1, "R1", "reset ready", wt_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    for (int r = 0; r < 8; r++) load_row(r, 1, 0);

    // R3/R4/R6/R7 sweep over lane width, row count and group length
    for (int nib = 0; nib < 2; nib++)
      for (int rc = 0; rc < 4; rc++)
        for (int n = 1; n <= 3; n += 2)
          run_group(nib ? "R4" : "R3", nib * 10 + rc * 3 + n, n, 1'(nib), rc, 0, 0);
    run_group("R6", 77, 7, 0, 3, 0, 0);

    // R2: reload one row, others keep earlier weights
    load_row(3, 9, 0);
    run_group("R2", 5, 2, 0, 3, 0, 0);

    // R8: write offered mid-group is dropped
    run_group("R8", 21, 2, 0, 3, 0, 1);
    run_group("R8", 22, 1, 0, 3, 0, 0);

    // R10: zero-weight padding lanes with arbitrary activations
    load_row(0, 4, 2);
    run_group("R10", 33, 3, 0, 3, 0, 0);
    run_group("R10", 34, 2, 1, 3, 0, 0);

    // R9: wrap-around after 4097 steps of (-128)*(-128) on 32 lanes
    for (int r = 0; r < 8; r++) load_row(r, 0, 1);
    run_group("R9", 0, 4097, 0, 3, 1, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule